// File: doc/BRIEF.md
# Zero-Fill Word Memory Completer for an APB Bus

This block is a 32-bit APB completer with no wait states that stores data in a word-addressed memory built from flip-flops. A requester writes words and reads them back over the standard setup/enable handshake. Any word that has not been written since the last reset reads back as zero. Each word carries a valid flag for this purpose, so the memory contents themselves never need to be cleared.

The active-low reset drops every valid flag in one step and forces the read data bus to zero. Only the low 4 KB window is decoded, and only word-aligned addresses are accepted. A write to any other address is dropped, and a read from any other address returns zero. The read data register is loaded from the memory at the end of the setup cycle. For this reason, a read placed directly after a write's enable cycle already sees the new word, and no bypass path is needed.

Top module: `apb_zmem_slave`

## Requirements
- R1: A transfer starts only when PSEL=1 and PENABLE=0 are sampled, and PWRITE in that cycle selects write (1) or read (0). With PSEL=0 nothing is stored, and PRDATA stays 0 during a read's setup cycle.
- R2: A write stores PWDATA into word PADDR[11:2] at the rising edge that ends its enable cycle (PSEL=1, PENABLE=1, PWRITE=1).
- R3: During a read's enable cycle, PRDATA holds the word most recently written to PADDR[11:2].
- R4: A word that has not been written since the last reset reads as 0.
- R5: While rst_n is 0, PRDATA is 0 and every word is invalidated, so all words read as 0 after reset is released.
- R6: An address with any of bits 31:12 or 1:0 set is outside the window. A write to it changes no word, and a read from it returns 0.
- R7: A read setup cycle that directly follows a write's enable cycle, with no idle cycle between them, returns the data just written to the same address.
- R8: PRDATA is 0 in every cycle that is not the enable cycle of a read.
- R9: A later write to the same word replaces the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| paddr | input | 32 | Byte address of the transfer |
| pwrite | input | 1 | 1 = write, 0 = read, sampled in the setup cycle |
| psel | input | 1 | Completer select |
| penable | input | 1 | Marks the enable (second) cycle of a transfer |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the read enable cycle, 0 otherwise |

## Verification
Writes and reads are each tried three ways: separated by idle cycles, back to back with no idle cycle between them, and as a read immediately after a write to the same word. These cases separate correct setup-cycle loading from a design that misses the newly written word or misses the second transfer. Unwritten words, out-of-window addresses and misaligned addresses are read after valid data has been placed at the same index, which shows whether the valid flag and the window decode gate the data correctly. A reset in the middle of the run, followed by reads of words written earlier, shows whether invalidation really takes effect. A behavioural reference memory predicts PRDATA for every cycle, which catches data that shows up in the wrong cycle.

// File: rtl/apb_zmem_pkg.sv
package apb_zmem_pkg;

    // Bus phase as seen by the completer in the current cycle
    typedef enum logic [2:0] {
        XFER_IDLE      = 3'd0,
        XFER_RD_SETUP  = 3'd1,
        XFER_WR_SETUP  = 3'd2,
        XFER_RD_ACCESS = 3'd3,
        XFER_WR_ACCESS = 3'd4
    } xfer_kind_e;

    function automatic xfer_kind_e classify(input logic sel, input logic en, input logic wr);
        if (!sel)
            return XFER_IDLE;
        else if (!en)
            return wr ? XFER_WR_SETUP : XFER_RD_SETUP;
        else
            return wr ? XFER_WR_ACCESS : XFER_RD_ACCESS;
    endfunction

endpackage

// File: rtl/apb_zmem_decode.sv
module apb_zmem_decode
    import apb_zmem_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 12,
    parameter int OFFS_W   = 2,
    localparam int IDX_W   = WIN_BITS - OFFS_W
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output xfer_kind_e        kind,
    output logic              in_window,
    output logic [IDX_W-1:0]  idx
);

    logic high_clear;
    logic low_clear;

    always_comb begin
        kind       = classify(psel, penable, pwrite);
        high_clear = (paddr[ADDR_W-1:WIN_BITS] == '0);
        low_clear  = (paddr[OFFS_W-1:0] == '0);
        in_window  = high_clear && low_clear;
        idx        = paddr[WIN_BITS-1:OFFS_W];
    end

endmodule

// File: rtl/apb_zmem_store.sv
module apb_zmem_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_valid
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  valid_d;
    logic [DEPTH-1:0]  valid_q;

    always_comb begin
        valid_d = valid_q;
        if (wr_en)
            valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_q <= '0;
        else
            valid_q <= valid_d;
    end

    // Contents need no reset: the valid flags mask stale words
    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_idx] <= wr_data;
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_word  = rd_valid ? mem_q[rd_idx] : '0;
    end

    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);  // R2

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));  // R5

endmodule

// File: rtl/apb_zmem_slave.sv
module apb_zmem_slave
    import apb_zmem_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WIN_BITS = 12,
    localparam int OFFS_W  = $clog2(DATA_W / 8),
    localparam int IDX_W   = WIN_BITS - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pwrite,
    input  logic              psel,
    input  logic              penable,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rd_live;
    } out_state_t;

    out_state_t        st_d;
    out_state_t        st_q;

    xfer_kind_e        kind;
    logic              in_window;
    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic [DATA_W-1:0] rd_word;
    logic              rd_valid;

    apb_zmem_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .OFFS_W   (OFFS_W)
    ) u_decode (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .kind      (kind),
        .in_window (in_window),
        .idx       (idx)
    );

    assign wr_en = (kind == XFER_WR_ACCESS) && in_window;

    apb_zmem_store #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (idx),
        .wr_data  (pwdata),
        .rd_idx   (idx),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

    // The read word is captured at the edge ending the setup cycle,
    // so it is on the bus for the whole enable cycle and cleared after.
    always_comb begin
        st_d = '0;
        if (kind == XFER_RD_SETUP) begin
            st_d.rd_live = 1'b1;
            if (in_window)
                st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign prdata = st_q.rdata;

    AST_RDATA_ONLY_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (prdata != '0) |-> $past(kind == XFER_RD_SETUP));  // R8

    AST_UNWRITTEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == XFER_RD_SETUP && !rd_valid) |=> (prdata == '0));  // R4

    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == XFER_RD_SETUP && !in_window) |=> (prdata == '0));  // R6

    AST_RESET_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (prdata == '0));  // R5

endmodule

// File: tb/apb_zmem_slave_tb.sv
`timescale 1ns/1ps
module apb_zmem_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] paddr = '0;
    logic        pwrite = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R5";

    bit [31:0] ref_mem [int];
    bit [31:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    apb_zmem_slave u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .paddr   (paddr),
        .pwrite  (pwrite),
        .psel    (psel),
        .penable (penable),
        .pwdata  (pwdata),
        .prdata  (prdata)
    );

    // Behavioural reference: predicts PRDATA for the next cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_mem.delete();
            exp_rd = '0;
        end else begin
            exp_rd = '0;
            if (psel && !penable && !pwrite &&
                paddr[31:12] == 0 && paddr[1:0] == 0 &&
                ref_mem.exists(int'(paddr[11:2])))
                exp_rd = ref_mem[int'(paddr[11:2])];
            if (psel && penable && pwrite && paddr[31:12] == 0 && paddr[1:0] == 0)
                ref_mem[int'(paddr[11:2])] = pwdata;
        end
    end

    // Cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (prdata !== exp_rd) begin
                fails++;
                $display("FAIL %s cycle compare: prdata actual %h expected %h", cur_req, prdata, exp_rd);
            end
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk); #1;
        penable = 1'b1;
    endtask

    task automatic do_read(input logic [31:0] a, output logic [31:0] d, output logic [31:0] setup_val);
        @(negedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        #1 setup_val = prdata;
        @(negedge clk); #1;
        penable = 1'b1;
        #1 d = prdata;
    endtask

    logic [31:0] rd, sv;

    initial begin
        repeat (3) @(negedge clk);
        #1 check_eq("R5 reset prdata", prdata, 32'h0);
        rst_n = 1'b1;

        cur_req = "R4";
        do_read(32'h040, rd, sv);
        check_eq("R4 unwritten word", rd, 32'h0);
        go_idle();

        cur_req = "R2";
        do_write(32'h040, 32'h1234_5678);
        #1 check_eq("R8 prdata in write enable", prdata, 32'h0);
        go_idle();
        do_read(32'h040, rd, sv);
        check_eq("R1 prdata zero in read setup", sv, 32'h0);
        check_eq("R3 read after write", rd, 32'h1234_5678);
        go_idle();
        #1 check_eq("R8 prdata after read", prdata, 32'h0);

        do_write(32'h0FFC, 32'hDEAD_BEEF);
        go_idle();
        do_read(32'h0FFC, rd, sv);
        check_eq("R2 top word", rd, 32'hDEAD_BEEF);
        go_idle();

        cur_req = "R7";
        do_write(32'h100, 32'hAAAA_0001);
        do_read(32'h100, rd, sv);
        check_eq("R7 read right after write", rd, 32'hAAAA_0001);
        do_write(32'h104, 32'h0BAD_0002);
        do_write(32'h108, 32'h0BAD_0003);
        do_read(32'h104, rd, sv);
        check_eq("R7 back-to-back writes, first", rd, 32'h0BAD_0002);
        do_read(32'h108, rd, sv);
        check_eq("R3 back-to-back reads", rd, 32'h0BAD_0003);
        go_idle();

        cur_req = "R6";
        do_write(32'h0000_1040, 32'hFFFF_FFFF);
        go_idle();
        do_write(32'h042, 32'h5555_5555);
        go_idle();
        do_read(32'h040, rd, sv);
        check_eq("R6 outside writes ignored", rd, 32'h1234_5678);
        go_idle();
        do_read(32'h0000_1040, rd, sv);
        check_eq("R6 outside read zero", rd, 32'h0);
        go_idle();
        do_read(32'h041, rd, sv);
        check_eq("R6 misaligned read zero", rd, 32'h0);
        go_idle();

        cur_req = "R1";
        @(negedge clk); #1;
        psel = 1'b0; pwrite = 1'b1; paddr = 32'h040; pwdata = 32'h1111_1111; penable = 1'b0;
        @(negedge clk); #1 penable = 1'b1;
        @(negedge clk); #1 penable = 1'b0;
        do_read(32'h040, rd, sv);
        check_eq("R1 unselected write ignored", rd, 32'h1234_5678);
        go_idle();

        cur_req = "R9";
        do_write(32'h040, 32'hCAFE_F00D);
        go_idle();
        do_read(32'h040, rd, sv);
        check_eq("R9 overwrite", rd, 32'hCAFE_F00D);
        go_idle();

        cur_req = "R5";
        @(negedge clk); #1 rst_n = 1'b0;
        #1 check_eq("R5 prdata in reset", prdata, 32'h0);
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        do_read(32'h040, rd, sv);
        check_eq("R5 word cleared", rd, 32'h0);
        do_read(32'h0FFC, rd, sv);
        check_eq("R5 top word cleared", rd, 32'h0);
        go_idle();
        repeat (3) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule